// File: doc/BRIEF.md
# Register Hazard and Forwarding Unit

This block sits beside the decode stage of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Every cycle it compares the two source register indices of the instruction in decode with the destination indices of the instructions now in execute, memory and write-back. From those comparisons it decides two things. The first is whether decode must hold, which freezes fetch and decode and puts a bubble into execute. The second is which bypass path each operand will use once the instruction reaches execute.

Source registers are read in decode and destination registers are written in write-back. The per-operand bypass selects are registered, so they apply to the instruction that is in execute. There are three select codes. Code 0 takes the operand read from the register file in decode. Code 1 takes the result held in the execute-to-memory latch. Code 2 takes the result held in the memory-to-write-back latch, which includes load data. A parameter chooses between two policies. With full forwarding, only an instruction that uses a load result and directly follows the load stalls, for one cycle. With stall-only, no bypass path exists (not even a register-file write-through), so any producer still in execute, memory or write-back holds the consumer.

Top module: `reg_hazard_fwd`

## Requirements
- R1: While reset is asserted, and after it is released with no source matching, both forward selects read 0.
- R2: Register index 0 never causes a stall and never yields a nonzero forward select.
- R3: In forwarding mode, if a source matches a non-load producer in execute, no stall is raised, and the select is 1 in the next cycle.
- R4: In forwarding mode, if a source matches a producer in memory (ALU result or load), no stall is raised, and the select is 2 in the next cycle.
- R5: In forwarding mode, if a source matches a load in execute, stall is raised for that cycle. A directly dependent instruction therefore stalls exactly once and then receives select 2.
- R6: In forwarding mode, a source that matches only the write-back producer raises no stall and gets select 0, because the register file writes before it reads.
- R7: If several stages match the same source, the youngest wins: execute over memory over write-back.
- R8: In stall-only mode, a match in execute, memory or write-back raises stall, and the selects stay 0. A consumer at distance 1, 2, 3 or 4 from its producer therefore stalls 3, 2, 1 or 0 cycles.
- R9: bubble equals stall. In the cycle after a stall, both selects are 0.
- R10: A stage whose write-enable is low never matches.
- R11: The two operands are resolved independently, and stall is raised if either operand needs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_rs1 | input | IDX_W | First source index of the decode instruction (0 = none) |
| id_rs2 | input | IDX_W | Second source index of the decode instruction (0 = none) |
| ex_rd | input | IDX_W | Destination index of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_ld | input | 1 | Execute instruction is a load |
| me_rd | input | IDX_W | Destination index of the memory-stage instruction |
| me_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | IDX_W | Destination index of the write-back instruction |
| wb_we | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Registered bypass select for operand 1 of the execute instruction |
| fwd_b | output | 2 | Registered bypass select for operand 2 of the execute instruction |
| stall | output | 1 | Hold fetch and decode this cycle |
| bubble | output | 1 | Insert a bubble into execute this cycle |

## Verification
A load-use stall on one operand can fall in the same cycle as a valid bypass on the other operand. The bench provokes this with a load in execute that feeds the second source while an ALU result in memory feeds the first. In that case the bubble must win: stall and bubble are high, and in the next cycle both selects read 0 rather than the code 2 the first operand would otherwise get. The distance sequences then move a producer stage by stage past a held consumer, for ALU and load producers under both policies. They count the stall cycles and check the select that is finally captured.

// File: rtl/reg_hazard_pkg.sv
package reg_hazard_pkg;

  // Bypass selects for an operand of the execute instruction
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,   // value read from the register file in decode
    FWD_MEM = 2'd1,   // result in the execute-to-memory latch
    FWD_WB  = 2'd2    // result in the memory-to-write-back latch
  } fwd_sel_e;

  typedef struct packed {
    logic ex;
    logic me;
    logic wb;
  } stage_hits_t;

endpackage

// File: rtl/rhf_match.sv
module rhf_match
  import reg_hazard_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic [IDX_W-1:0] me_rd,
  input  logic             me_we,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_we,
  output stage_hits_t      hits
);

  logic src_live;

  // index zero is hard-wired and never a dependence
  assign src_live = (src != '0);

  always_comb begin
    hits.ex = src_live && ex_we && (ex_rd == src);
    hits.me = src_live && me_we && (me_rd == src);
    hits.wb = src_live && wb_we && (wb_rd == src);
  end

endmodule

// File: rtl/rhf_resolve.sv
module rhf_resolve
  import reg_hazard_pkg::*;
#(
  parameter bit FWD_EN = 1'b1
) (
  input  stage_hits_t hits,
  input  logic        ex_ld,
  output logic        need_stall,
  output fwd_sel_e    sel_nxt
);

  generate
    if (FWD_EN) begin : g_fwd
      // youngest producer first; a load in execute has no data yet
      always_comb begin
        need_stall = 1'b0;
        sel_nxt    = FWD_RF;
        if (hits.ex) begin
          if (ex_ld) begin
            need_stall = 1'b1;
          end else begin
            sel_nxt = FWD_MEM;
          end
        end else if (hits.me) begin
          sel_nxt = FWD_WB;
        end
      end
    end else begin : g_stall_only
      // no bypass at all: every in-flight producer holds decode
      always_comb begin
        need_stall = hits.ex | hits.me | hits.wb;
        sel_nxt    = FWD_RF;
      end
    end
  endgenerate

endmodule

// File: rtl/rhf_sel_reg.sv
module rhf_sel_reg
  import reg_hazard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bubble,
  input  fwd_sel_e sel_in,
  output fwd_sel_e sel_q
);

  fwd_sel_e sel_d;

  always_comb begin
    if (bubble) begin
      sel_d = FWD_RF;
    end else begin
      sel_d = sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= FWD_RF;
    end else begin
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/reg_hazard_fwd.sv
module reg_hazard_fwd
  import reg_hazard_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_rs1,
  input  logic [IDX_W-1:0] id_rs2,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_ld,
  input  logic [IDX_W-1:0] me_rd,
  input  logic             me_we,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall,
  output logic             bubble
);

  localparam int unsigned NUM_SRC = 2;

  logic                 rst_meta_n;
  logic                 rst_core_n;
  logic [IDX_W-1:0]     src_idx   [NUM_SRC];
  stage_hits_t          src_hits  [NUM_SRC];
  fwd_sel_e             src_nxt   [NUM_SRC];
  fwd_sel_e             src_sel_q [NUM_SRC];
  logic [NUM_SRC-1:0]   src_stall;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  assign src_idx[0] = id_rs1;
  assign src_idx[1] = id_rs2;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      rhf_match #(.IDX_W(IDX_W)) u_match (
        .src   (src_idx[s]),
        .ex_rd (ex_rd),
        .ex_we (ex_we),
        .me_rd (me_rd),
        .me_we (me_we),
        .wb_rd (wb_rd),
        .wb_we (wb_we),
        .hits  (src_hits[s])
      );

      rhf_resolve #(.FWD_EN(FWD_EN)) u_resolve (
        .hits       (src_hits[s]),
        .ex_ld      (ex_ld),
        .need_stall (src_stall[s]),
        .sel_nxt    (src_nxt[s])
      );

      rhf_sel_reg u_sel (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .bubble (stall),
        .sel_in (src_nxt[s]),
        .sel_q  (src_sel_q[s])
      );
    end
  endgenerate

  assign stall  = |src_stall;
  assign bubble = stall;
  assign fwd_a  = src_sel_q[0];
  assign fwd_b  = src_sel_q[1];

  // R9: a bubble in execute carries no bypass
  p_bubble_clears_sel_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    stall |=> (fwd_a == 2'd0 && fwd_b == 2'd0));

  // R2: the zero register is never bypassed
  p_zero_never_fwd_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (id_rs1 == '0) |=> (fwd_a == 2'd0));

  generate
    if (FWD_EN) begin : g_fwd_chk
      // R3: ALU result in execute bypasses from the memory latch
      p_alu_ex_fwd_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
        (ex_we && !ex_ld && ex_rd != '0 && ex_rd == id_rs1 && !stall) |=> (fwd_a == 2'd1));
      // R5: load in execute feeding a source must hold decode
      p_load_use_stall_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
        (ex_we && ex_ld && ex_rd != '0 && ex_rd == id_rs2) |-> stall);
    end else begin : g_so_chk
      // R8: without bypass even a write-back producer holds decode
      p_wb_holds_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
        (wb_we && wb_rd != '0 && wb_rd == id_rs1) |-> stall);
    end
  endgenerate

endmodule

// File: tb/tb_reg_hazard_fwd.sv
`timescale 1ns/1ps
module tb_reg_hazard_fwd;

  localparam int W = 5;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] id_rs1, id_rs2, ex_rd, me_rd, wb_rd;
  logic         ex_we, ex_ld, me_we, wb_we;
  logic [1:0]   fa_f, fb_f, fa_s, fb_s;
  logic         st_f, bb_f, st_s, bb_s;

  int checks = 0;
  int fails  = 0;

  reg_hazard_fwd #(.IDX_W(W), .FWD_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_ld(ex_ld), .me_rd(me_rd), .me_we(me_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .fwd_a(fa_f), .fwd_b(fb_f), .stall(st_f), .bubble(bb_f)
  );

  reg_hazard_fwd #(.IDX_W(W), .FWD_EN(1'b0)) dut_so (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_ld(ex_ld), .me_rd(me_rd), .me_we(me_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .fwd_a(fa_s), .fwd_b(fb_s), .stall(st_s), .bubble(bb_s)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [4:0] rs1; logic [4:0] rs2;
    logic [4:0] exrd; logic exwe; logic exld;
    logic [4:0] merd; logic mewe;
    logic [4:0] wbrd; logic wbwe;
    logic st_f; logic [1:0] a_f; logic [1:0] b_f; logic st_s;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{5'd1,  5'd2,  5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 2'd1, 2'd0, 1'b1}, // R3
    '{5'd3,  5'd3,  5'd0,  1'b0, 1'b0, 5'd3,  1'b1, 5'd0,  1'b0, 1'b0, 2'd2, 2'd2, 1'b1}, // R4
    '{5'd4,  5'd0,  5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd4,  1'b1, 1'b0, 2'd0, 2'd0, 1'b1}, // R6
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 5'd0,  1'b1, 1'b0, 2'd0, 2'd0, 1'b0}, // R2
    '{5'd5,  5'd5,  5'd5,  1'b0, 1'b0, 5'd5,  1'b0, 5'd5,  1'b0, 1'b0, 2'd0, 2'd0, 1'b0}, // R10
    '{5'd6,  5'd0,  5'd6,  1'b1, 1'b0, 5'd6,  1'b1, 5'd6,  1'b1, 1'b0, 2'd1, 2'd0, 1'b1}, // R7
    '{5'd7,  5'd0,  5'd0,  1'b0, 1'b0, 5'd7,  1'b1, 5'd7,  1'b1, 1'b0, 2'd2, 2'd0, 1'b1}, // R7
    '{5'd9,  5'd8,  5'd8,  1'b1, 1'b1, 5'd9,  1'b1, 5'd0,  1'b0, 1'b1, 2'd0, 2'd0, 1'b1}, // R5 R9 R11
    '{5'd10, 5'd0,  5'd0,  1'b0, 1'b0, 5'd10, 1'b1, 5'd0,  1'b0, 1'b0, 2'd2, 2'd0, 1'b1}, // R4 load in ME
    '{5'd11, 5'd12, 5'd11, 1'b1, 1'b0, 5'd12, 1'b1, 5'd0,  1'b0, 1'b0, 2'd1, 2'd2, 1'b1}, // R11
    '{5'd14, 5'd0,  5'd13, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 2'd0, 1'b0}, // R5 no consumer
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 2'd0, 2'd0, 1'b0}  // R2 load to r0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs1 = '0; id_rs2 = '0;
    ex_rd = '0; ex_we = 1'b0; ex_ld = 1'b0;
    me_rd = '0; me_we = 1'b0; wb_rd = '0; wb_we = 1'b0;
  endtask

  // producer of r15 starts d stages ahead of the consumer in decode
  task automatic dist_run(input bit use_fwd, input int d, input bit ld,
                          input int exp_st, input int exp_sel, input string req);
    int p = d;
    int cnt = 0;
    int sel = -1;
    for (int guard = 0; guard < 6; guard++) begin
      @(negedge clk);
      idle();
      id_rs1 = 5'd15;
      if (p == 1) begin ex_rd = 5'd15; ex_we = 1'b1; ex_ld = ld; end
      if (p == 2) begin me_rd = 5'd15; me_we = 1'b1; end
      if (p == 3) begin wb_rd = 5'd15; wb_we = 1'b1; end
      #1;
      if (use_fwd ? st_f : st_s) begin
        cnt++;
        p++;
        @(posedge clk);
      end else begin
        @(posedge clk);
        #1;
        sel = use_fwd ? int'(fa_f) : int'(fa_s);
        break;
      end
    end
    chk({req, " stall cycles"}, cnt, exp_st);
    chk({req, " select"}, sel, exp_sel);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    // R1: selects held at 0 during reset even with a matching source
    @(negedge clk);
    id_rs1 = 5'd1; ex_rd = 5'd1; ex_we = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset fwd_a", fa_f, 0);
    @(negedge clk);
    idle();
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 after reset fwd_a", fa_f, 0);
    chk("R1 after reset fwd_b", fb_f, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      id_rs1 = VEC[i].rs1; id_rs2 = VEC[i].rs2;
      ex_rd = VEC[i].exrd; ex_we = VEC[i].exwe; ex_ld = VEC[i].exld;
      me_rd = VEC[i].merd; me_we = VEC[i].mewe;
      wb_rd = VEC[i].wbrd; wb_we = VEC[i].wbwe;
      #1;
      chk($sformatf("R5 R3 vec%0d fwd-mode stall", i), st_f, VEC[i].st_f);
      chk($sformatf("R9 vec%0d fwd-mode bubble", i), bb_f, VEC[i].st_f);
      chk($sformatf("R8 vec%0d stall-mode stall", i), st_s, VEC[i].st_s);
      chk($sformatf("R9 vec%0d stall-mode bubble", i), bb_s, VEC[i].st_s);
      @(posedge clk); #1;
      chk($sformatf("R7 R11 vec%0d fwd_a", i), fa_f, VEC[i].a_f);
      chk($sformatf("R7 R11 vec%0d fwd_b", i), fb_f, VEC[i].b_f);
      chk($sformatf("R8 vec%0d stall-mode fwd_a", i), fa_s, 0);
      chk($sformatf("R8 vec%0d stall-mode fwd_b", i), fb_s, 0);
    end
    @(negedge clk);
    idle();

    // forwarding mode, ALU producer: distances 1..4
    dist_run(1'b1, 1, 1'b0, 0, 1, "R3 alu d1");
    dist_run(1'b1, 2, 1'b0, 0, 2, "R4 alu d2");
    dist_run(1'b1, 3, 1'b0, 0, 0, "R6 alu d3");
    dist_run(1'b1, 4, 1'b0, 0, 0, "R6 alu d4");
    // forwarding mode, load producer
    dist_run(1'b1, 1, 1'b1, 1, 2, "R5 load d1");
    dist_run(1'b1, 2, 1'b1, 0, 2, "R4 load d2");
    dist_run(1'b1, 3, 1'b1, 0, 0, "R6 load d3");
    dist_run(1'b1, 4, 1'b1, 0, 0, "R6 load d4");
    // stall-only mode
    dist_run(1'b0, 1, 1'b0, 3, 0, "R8 alu d1");
    dist_run(1'b0, 2, 1'b0, 2, 0, "R8 alu d2");
    dist_run(1'b0, 3, 1'b0, 1, 0, "R8 alu d3");
    dist_run(1'b0, 4, 1'b0, 0, 0, "R8 alu d4");
    dist_run(1'b0, 1, 1'b1, 3, 0, "R8 load d1");
    dist_run(1'b0, 4, 1'b1, 0, 0, "R8 load d4");

    // R10: write-enable low in all stages, same index everywhere
    @(negedge clk);
    id_rs1 = 5'd20; id_rs2 = 5'd20; ex_rd = 5'd20; ex_ld = 1'b1;
    me_rd = 5'd20; wb_rd = 5'd20;
    #1;
    chk("R10 fwd-mode stall", st_f, 0);
    chk("R10 stall-mode stall", st_s, 0);
    @(posedge clk); #1;
    chk("R10 fwd_b", fb_f, 0);
    @(negedge clk);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule